// File: doc/BRIEF.md
# Idle Command Handshake Sequencer

This block lets host-side logic hand one command to an embedded processor through a word-addressed shared memory and then wait for the outcome. For each command it first writes zero into a status word. It then stores a 32-bit argument as two 16-bit words, low half first, and stores the 16-bit command word after both halves. Only then does it pulse a doorbell line. From that point it reads the status word at a fixed interval until the responder leaves a nonzero value there. If no nonzero value appears within a bounded number of reads, the command ends as a timeout.

A second request input runs a bus-reset sequence. This is two commands in a row, a reset-begin and a reset-end, each with a zero argument and separated by a programmable hold delay. The sequence counts as successful only when both commands return the success code. Every shared-memory access is a request held until its acknowledge, and only one access is outstanding at any time. The poll interval, the poll limit and the hold delay are parameters. Their defaults give a 20 µs interval, 5,000,000 polls and a 100 µs hold at 200 MHz.

Top module: `idlecmd_seq`

## Requirements
- R1: The first access of every command is a write of 0x0000 to word address STAT_ADDR.
- R2: The argument's bits 15:0 are written to ARG_ADDR and its bits 31:16 to ARG_ADDR+1. Both writes are acknowledged before the command word is written to CMD_ADDR, and each command makes exactly these four writes.
- R3: `doorbell` is a one-cycle pulse issued once per command. It follows the acknowledged command-word write, and no memory access comes between that write and the pulse.
- R4: Status reads start no sooner than POLL_INTERVAL cycles after the doorbell or after the previous status read completed.
- R5: The first status read that returns nonzero ends the command. `done` pulses for one cycle, `status_out` carries the value read, `timed_out` and `failed` are 0, and no further read of that command follows.
- R6: After POLL_LIMIT status reads that all returned zero, the command ends with `timed_out`=1, `failed`=1 and `status_out`=0. At most POLL_LIMIT status reads are made.
- R7: `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_ack` is seen, and a new access begins only after that.
- R8: `busy` rises in the cycle after an accepted request and falls in the same cycle `done` pulses. While `busy` is high, `start` and `bus_reset_req` are ignored, and no memory access is made while `busy` is low.
- R9: A bus reset sends RST_BEGIN_CODE with a zero argument. If that returns OK_CODE, it waits at least HOLD_CYCLES and then sends RST_FINISH_CODE with a zero argument. `failed` is 0 only if both commands return OK_CODE. A failed or timed-out first command ends the sequence without a second command, and `status_out` holds the last status read.
- R10: When `start` and `bus_reset_req` arrive in the same cycle, only the single command runs.
- R11: After reset, `busy`, `done`, `doorbell`, `mem_req`, `timed_out`, `failed` and `status_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a single command |
| cmd_in | input | 16 | Command word for a single command |
| arg_in | input | 32 | Argument for a single command |
| bus_reset_req | input | 1 | Request the two-command bus-reset sequence |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| status_out | output | 16 | Last status read (0 on timeout) |
| timed_out | output | 1 | Last command hit the poll limit |
| failed | output | 1 | Operation did not succeed |
| doorbell | output | 1 | One-cycle pulse telling the processor to act |
| mem_req | output | 1 | Shared-memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access acknowledge |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |

## Verification
Single commands are swept over the read on which the responder first answers, from the first read to one past the poll limit, plus a responder that never answers. Each case is run at three acknowledge latencies. This separates a hit on the final allowed poll from a timeout, and it shows that the write order and data do not depend on memory latency. Bus resets are run with each outcome of the first command (success, error code, timeout) crossed with each outcome of the second. This shows whether the second command is suppressed, whether the hold gap is kept and how the failure flag is formed. Requests made while busy, and start arriving together with a bus-reset request, check that the extra requests leave no trace in the write log or the doorbell count.

// File: rtl/idlecmd_pkg.sv
package idlecmd_pkg;
  localparam int WORD_W = 16;
  localparam int ARG_W  = 32;

  typedef enum logic [2:0] {
    E_IDLE, E_CLR, E_ARGLO, E_ARGHI, E_CMD, E_WAIT, E_POLL
  } eng_state_t;

  typedef enum logic [2:0] {
    W_IDLE, W_SINGLE, W_RST_A, W_HOLD, W_RST_B
  } wrap_state_t;
endpackage

// File: rtl/idlecmd_memport.sv
module idlecmd_memport
  import idlecmd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              go_we,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [WORD_W-1:0] go_wdata,
  output logic              acc_done,
  output logic [WORD_W-1:0] acc_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      acc_done  <= 1'b0;
      acc_rdata <= '0;
    end else begin
      acc_done <= 1'b0;
      if (mem_req) begin
        if (mem_ack) begin
          mem_req   <= 1'b0;
          acc_done  <= 1'b1;
          acc_rdata <= mem_rdata;
        end
      end else if (go) begin
        mem_req   <= 1'b1;
        mem_we    <= go_we;
        mem_addr  <= go_addr;
        mem_wdata <= go_wdata;
      end
    end
  end
endmodule

// File: rtl/idlecmd_ticker.sv
module idlecmd_ticker #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic             active;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (load) begin
        cnt    <= load_val;
        active <= 1'b1;
      end else if (active) begin
        if (cnt <= CNT_W'(1)) begin
          active <= 1'b0;
          expire <= 1'b1;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/idlecmd_engine.sv
module idlecmd_engine
  import idlecmd_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int STAT_ADDR  = 0,
  parameter int ARG_ADDR   = 2,
  parameter int CMD_ADDR   = 4,
  parameter int POLL_LIMIT = 5000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [WORD_W-1:0] cmd,
  input  logic [ARG_W-1:0]  arg,
  output logic              acc_go,
  output logic              acc_we,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [WORD_W-1:0] acc_wdata,
  input  logic              acc_done,
  input  logic [WORD_W-1:0] acc_rdata,
  output logic              tmr_load,
  input  logic              tmr_expire,
  output logic              doorbell,
  output logic              fin,
  output logic [WORD_W-1:0] fin_status,
  output logic              fin_tout
);
  localparam int PC_W = $clog2(POLL_LIMIT + 1);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_ARG_LO = ADDR_W'(ARG_ADDR);
  localparam logic [ADDR_W-1:0] A_ARG_HI = ADDR_W'(ARG_ADDR + 1);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(CMD_ADDR);
  localparam logic [PC_W-1:0]   LAST_POLL = PC_W'(POLL_LIMIT - 1);

  eng_state_t        state;
  logic [WORD_W-1:0] cmd_q;
  logic [ARG_W-1:0]  arg_q;
  logic [PC_W-1:0]   polls;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= E_IDLE;
      cmd_q      <= '0;
      arg_q      <= '0;
      polls      <= '0;
      acc_go     <= 1'b0;
      acc_we     <= 1'b0;
      acc_addr   <= '0;
      acc_wdata  <= '0;
      tmr_load   <= 1'b0;
      doorbell   <= 1'b0;
      fin        <= 1'b0;
      fin_status <= '0;
      fin_tout   <= 1'b0;
    end else begin
      acc_go   <= 1'b0;
      tmr_load <= 1'b0;
      doorbell <= 1'b0;
      fin      <= 1'b0;
      unique case (state)
        E_IDLE: if (go) begin
          cmd_q     <= cmd;
          arg_q     <= arg;
          acc_go    <= 1'b1;
          acc_we    <= 1'b1;
          acc_addr  <= A_STAT;
          acc_wdata <= '0;
          state     <= E_CLR;
        end
        E_CLR: if (acc_done) begin
          acc_go    <= 1'b1;
          acc_we    <= 1'b1;
          acc_addr  <= A_ARG_LO;
          acc_wdata <= arg_q[WORD_W-1:0];
          state     <= E_ARGLO;
        end
        E_ARGLO: if (acc_done) begin
          acc_go    <= 1'b1;
          acc_we    <= 1'b1;
          acc_addr  <= A_ARG_HI;
          acc_wdata <= arg_q[ARG_W-1:WORD_W];
          state     <= E_ARGHI;
        end
        E_ARGHI: if (acc_done) begin
          acc_go    <= 1'b1;
          acc_we    <= 1'b1;
          acc_addr  <= A_CMD;
          acc_wdata <= cmd_q;
          state     <= E_CMD;
        end
        E_CMD: if (acc_done) begin
          doorbell <= 1'b1;
          tmr_load <= 1'b1;
          polls    <= '0;
          state    <= E_WAIT;
        end
        E_WAIT: if (tmr_expire) begin
          acc_go   <= 1'b1;
          acc_we   <= 1'b0;
          acc_addr <= A_STAT;
          state    <= E_POLL;
        end
        E_POLL: if (acc_done) begin
          if (acc_rdata != '0) begin
            fin        <= 1'b1;
            fin_status <= acc_rdata;
            fin_tout   <= 1'b0;
            state      <= E_IDLE;
          end else if (polls == LAST_POLL) begin
            fin        <= 1'b1;
            fin_status <= '0;
            fin_tout   <= 1'b1;
            state      <= E_IDLE;
          end else begin
            polls    <= polls + PC_W'(1);
            tmr_load <= 1'b1;
            state    <= E_WAIT;
          end
        end
        default: state <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idlecmd_seq.sv
module idlecmd_seq
  import idlecmd_pkg::*;
#(
  parameter int          ADDR_W          = 8,
  parameter int          STAT_ADDR       = 0,
  parameter int          ARG_ADDR        = 2,
  parameter int          CMD_ADDR        = 4,
  parameter int          POLL_INTERVAL   = 4000,
  parameter int          POLL_LIMIT      = 5000000,
  parameter int          HOLD_CYCLES     = 20000,
  parameter logic [15:0] RST_BEGIN_CODE  = 16'h0011,
  parameter logic [15:0] RST_FINISH_CODE = 16'h0012,
  parameter logic [15:0] OK_CODE         = 16'h0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [15:0]       cmd_in,
  input  logic [31:0]       arg_in,
  input  logic              bus_reset_req,
  output logic              busy,
  output logic              done,
  output logic [15:0]       status_out,
  output logic              timed_out,
  output logic              failed,
  output logic              doorbell,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [15:0]       mem_rdata
);
  localparam int TMR_MAX = (POLL_INTERVAL > HOLD_CYCLES) ? POLL_INTERVAL : HOLD_CYCLES;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] POLL_TV = TMR_W'(POLL_INTERVAL);
  localparam logic [TMR_W-1:0] HOLD_TV = TMR_W'(HOLD_CYCLES);

  wrap_state_t       wstate;
  logic              eng_go;
  logic [WORD_W-1:0] eng_cmd;
  logic [ARG_W-1:0]  eng_arg;
  logic              hold_load;

  logic              acc_go, acc_we, acc_done;
  logic [ADDR_W-1:0] acc_addr;
  logic [WORD_W-1:0] acc_wdata, acc_rdata;
  logic              eng_tload, tmr_load, tmr_expire;
  logic [TMR_W-1:0]  tmr_val;
  logic              fin, fin_tout;
  logic [WORD_W-1:0] fin_status;
  logic              fin_bad;

  assign tmr_load = eng_tload | hold_load;
  assign tmr_val  = hold_load ? HOLD_TV : POLL_TV;
  assign fin_bad  = fin_tout || (fin_status != OK_CODE);

  idlecmd_engine #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .ARG_ADDR(ARG_ADDR),
    .CMD_ADDR(CMD_ADDR), .POLL_LIMIT(POLL_LIMIT)
  ) u_engine (
    .clk(clk), .rst(rst), .go(eng_go), .cmd(eng_cmd), .arg(eng_arg),
    .acc_go(acc_go), .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_done(acc_done), .acc_rdata(acc_rdata),
    .tmr_load(eng_tload), .tmr_expire(tmr_expire), .doorbell(doorbell),
    .fin(fin), .fin_status(fin_status), .fin_tout(fin_tout)
  );

  idlecmd_memport #(.ADDR_W(ADDR_W)) u_memport (
    .clk(clk), .rst(rst), .go(acc_go), .go_we(acc_we), .go_addr(acc_addr),
    .go_wdata(acc_wdata), .acc_done(acc_done), .acc_rdata(acc_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  idlecmd_ticker #(.CNT_W(TMR_W)) u_ticker (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expire(tmr_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wstate     <= W_IDLE;
      eng_go     <= 1'b0;
      eng_cmd    <= '0;
      eng_arg    <= '0;
      hold_load  <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      status_out <= '0;
      timed_out  <= 1'b0;
      failed     <= 1'b0;
    end else begin
      eng_go    <= 1'b0;
      hold_load <= 1'b0;
      done      <= 1'b0;
      unique case (wstate)
        W_IDLE: begin
          if (start) begin
            eng_go  <= 1'b1;
            eng_cmd <= cmd_in;
            eng_arg <= arg_in;
            busy    <= 1'b1;
            wstate  <= W_SINGLE;
          end else if (bus_reset_req) begin
            eng_go  <= 1'b1;
            eng_cmd <= RST_BEGIN_CODE;
            eng_arg <= '0;
            busy    <= 1'b1;
            wstate  <= W_RST_A;
          end
        end
        W_SINGLE: if (fin) begin
          done       <= 1'b1;
          busy       <= 1'b0;
          status_out <= fin_status;
          timed_out  <= fin_tout;
          failed     <= fin_tout;
          wstate     <= W_IDLE;
        end
        W_RST_A: if (fin) begin
          if (fin_bad) begin
            done       <= 1'b1;
            busy       <= 1'b0;
            status_out <= fin_status;
            timed_out  <= fin_tout;
            failed     <= 1'b1;
            wstate     <= W_IDLE;
          end else begin
            hold_load <= 1'b1;
            wstate    <= W_HOLD;
          end
        end
        W_HOLD: if (tmr_expire) begin
          eng_go  <= 1'b1;
          eng_cmd <= RST_FINISH_CODE;
          eng_arg <= '0;
          wstate  <= W_RST_B;
        end
        W_RST_B: if (fin) begin
          done       <= 1'b1;
          busy       <= 1'b0;
          status_out <= fin_status;
          timed_out  <= fin_tout;
          failed     <= fin_bad;
          wstate     <= W_IDLE;
        end
        default: wstate <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idlecmd_seq_chk.sv
module idlecmd_seq_chk #(
  parameter int ADDR_W        = 8,
  parameter int STAT_ADDR     = 0,
  parameter int ARG_ADDR      = 2,
  parameter int CMD_ADDR      = 4,
  parameter int POLL_INTERVAL = 4000
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic [15:0]       status_out,
  input logic              timed_out,
  input logic              failed,
  input logic              doorbell,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [15:0]       mem_wdata,
  input logic              mem_ack
);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_ARG_HI = ADDR_W'(ARG_ADDR + 1);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(CMD_ADDR);

  logic        hi_seen;
  logic        last_was_cmd;
  logic        req_q;
  logic [31:0] gap;
  logic        xfer;

  assign xfer = mem_req && mem_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_seen      <= 1'b0;
      last_was_cmd <= 1'b0;
      req_q        <= 1'b0;
      gap          <= '0;
    end else begin
      req_q <= mem_req;
      if (xfer && mem_we && mem_addr == A_ARG_HI) hi_seen <= 1'b1;
      else if (doorbell) hi_seen <= 1'b0;
      if (xfer) last_was_cmd <= mem_we && (mem_addr == A_CMD);
      else if (doorbell) last_was_cmd <= 1'b0;
      if (doorbell || (xfer && !mem_we && mem_addr == A_STAT)) gap <= '0;
      else if (gap != 32'hFFFF_FFFF) gap <= gap + 32'd1;
    end
  end

  AST_CLEAR_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_addr == A_STAT) |-> (mem_wdata == 16'h0000)); // R1
  AST_ARG_BEFORE_CMD: assert property (@(posedge clk) disable iff (rst)
    (xfer && mem_we && mem_addr == A_CMD) |-> hi_seen); // R2
  AST_BELL_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
    doorbell |-> last_was_cmd); // R3
  AST_BELL_PULSE: assert property (@(posedge clk) disable iff (rst)
    doorbell |=> !doorbell); // R3
  AST_POLL_SPACING: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !req_q && !mem_we && mem_addr == A_STAT) |-> (gap >= 32'(POLL_INTERVAL))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5
  AST_TIMEOUT_FAILS: assert property (@(posedge clk) disable iff (rst)
    (done && timed_out) |-> (failed && status_out == 16'h0000)); // R6
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R8
  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R8
endmodule

bind idlecmd_seq idlecmd_seq_chk #(
  .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .ARG_ADDR(ARG_ADDR),
  .CMD_ADDR(CMD_ADDR), .POLL_INTERVAL(POLL_INTERVAL)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .status_out(status_out),
  .timed_out(timed_out), .failed(failed), .doorbell(doorbell),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/idlecmd_seq_test.sv
`timescale 1ns/1ps
module idlecmd_seq_test;
  localparam int          AW    = 4;
  localparam int          STA   = 2;
  localparam int          ARGA  = 4;
  localparam int          CMDA  = 7;
  localparam int          PI    = 5;
  localparam int          PL    = 6;
  localparam int          HOLD  = 20;
  localparam logic [15:0] RBEG  = 16'h0011;
  localparam logic [15:0] RFIN  = 16'h0012;
  localparam logic [15:0] OKC   = 16'h0001;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [15:0]   cmd_in = '0;
  logic [31:0]   arg_in = '0;
  logic          bus_reset_req = 1'b0;
  logic          busy, done, timed_out, failed, doorbell;
  logic [15:0]   status_out;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata;
  logic          mem_ack;
  logic [15:0]   mem_rdata;

  always #2.5 clk = ~clk;

  idlecmd_seq #(
    .ADDR_W(AW), .STAT_ADDR(STA), .ARG_ADDR(ARGA), .CMD_ADDR(CMDA),
    .POLL_INTERVAL(PI), .POLL_LIMIT(PL), .HOLD_CYCLES(HOLD),
    .RST_BEGIN_CODE(RBEG), .RST_FINISH_CODE(RFIN), .OK_CODE(OKC)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .cmd_in(cmd_in), .arg_in(arg_in),
    .bus_reset_req(bus_reset_req), .busy(busy), .done(done),
    .status_out(status_out), .timed_out(timed_out), .failed(failed),
    .doorbell(doorbell), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  // ---------------- responder stub ----------------
  int          ack_lat = 0;
  logic        stub_clr = 1'b0;
  int          cfg_after [4];
  logic [15:0] cfg_val   [4];

  logic        ack_r;
  logic [15:0] rdata_r;
  int          wcnt, wn, bells, sreads, cyc;
  logic [AW-1:0] wlog_a [16];
  logic [15:0] wlog_d [16];
  int          bell_wn [4];
  int          reads_per [4];
  int          prev_mark, min_gap, last_rd_ack, hold_gap;
  logic        req_q;
  logic [15:0] stub_reply;
  int          bidx;

  assign mem_ack   = ack_r;
  assign mem_rdata = rdata_r;

  always_comb begin
    bidx = (bells >= 1 && bells <= 4) ? bells - 1 : 0;
    stub_reply = (cfg_after[bidx] != 0 && sreads + 1 >= cfg_after[bidx]) ? cfg_val[bidx] : 16'h0000;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc     <= 0;
      min_gap <= 1000000;
    end else begin
      cyc <= cyc + 1;
      if (mem_req && !req_q && !mem_we && mem_addr == AW'(STA)) begin
        if (cyc - prev_mark < min_gap) min_gap <= cyc - prev_mark;
      end
    end
    if (rst || stub_clr) begin
      ack_r <= 1'b0; rdata_r <= '0; wcnt <= 0; wn <= 0; bells <= 0; sreads <= 0;
      req_q <= 1'b0; prev_mark <= 0; last_rd_ack <= 0; hold_gap <= -1;
      for (int i = 0; i < 4; i++) begin reads_per[i] <= 0; bell_wn[i] <= 0; end
      for (int i = 0; i < 16; i++) begin wlog_a[i] <= '0; wlog_d[i] <= '0; end
    end else begin
      req_q <= mem_req;
      if (ack_r) ack_r <= 1'b0;
      else if (mem_req) begin
        if (wcnt >= ack_lat) begin
          ack_r <= 1'b1;
          wcnt  <= 0;
          if (mem_we) begin
            if (wn < 16) begin wlog_a[wn] <= mem_addr; wlog_d[wn] <= mem_wdata; end
            wn <= wn + 1;
            rdata_r <= '0;
          end else if (mem_addr == AW'(STA)) begin
            rdata_r <= stub_reply;
            sreads <= sreads + 1;
            reads_per[bidx] <= reads_per[bidx] + 1;
            last_rd_ack <= cyc;
            prev_mark <= cyc;
          end else rdata_r <= '0;
        end else wcnt <= wcnt + 1;
      end
      if (mem_req && !req_q && mem_we && mem_addr == AW'(STA) && bells == 1)
        hold_gap <= cyc - last_rd_ack;
      if (doorbell) begin
        if (bells < 4) bell_wn[bells] <= wn;
        bells <= bells + 1;
        sreads <= 0;
        prev_mark <= cyc;
      end
    end
  end

  // ---------------- checking ----------------
  int vectors = 0;
  int fails = 0;
  logic [15:0] r_status;
  logic r_tout, r_fail;
  logic busy_seen;

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_stub();
    @(negedge clk); stub_clr = 1'b1;
    @(negedge clk); stub_clr = 1'b0;
  endtask

  task automatic wait_done();
    int k;
    k = 0;
    while (!done && k < 20000) begin @(negedge clk); k++; end
    r_status = status_out; r_tout = timed_out; r_fail = failed;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_op(input logic is_bus, input logic [15:0] c, input logic [31:0] a);
    @(negedge clk);
    cmd_in = c; arg_in = a;
    if (is_bus) bus_reset_req = 1'b1; else start = 1'b1;
    @(negedge clk);
    start = 1'b0; bus_reset_req = 1'b0;
    busy_seen = busy;
    wait_done();
  endtask

  function automatic int exp_reads(input int after);
    return (after >= 1 && after <= PL) ? after : PL;
  endfunction

  task automatic chk_cmd_writes(input int base, input logic [15:0] c, input logic [31:0] a);
    chk(wlog_a[base] == AW'(STA) && wlog_d[base] == 16'h0, "R1 clear first", wlog_d[base], 0);
    chk(wlog_a[base+1] == AW'(ARGA) && wlog_d[base+1] == a[15:0], "R2 arg low", wlog_d[base+1], a[15:0]);
    chk(wlog_a[base+2] == AW'(ARGA+1) && wlog_d[base+2] == a[31:16], "R2 arg high", wlog_d[base+2], a[31:16]);
    chk(wlog_a[base+3] == AW'(CMDA) && wlog_d[base+3] == c, "R2 cmd last", wlog_d[base+3], c);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin cfg_after[i] = 0; cfg_val[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !doorbell && !mem_req && !timed_out && !failed && status_out == 0,
        "R11 reset state", {busy, done, doorbell, mem_req, timed_out, failed}, 0);

    // Single-command sweep: reply on read n (0 = never) at each ack latency
    for (int lat = 0; lat < 3; lat++) begin
      for (int n = 0; n <= PL + 1; n++) begin
        logic [15:0] c;
        logic [31:0] a;
        logic        ok;
        c = 16'h0100 + 16'(n) + 16'(lat << 4);
        a = 32'hA5C3_0000 ^ (32'(n) << 20) ^ 32'(lat * 77 + n);
        ack_lat = lat;
        cfg_after[0] = n;
        cfg_val[0] = 16'h8000 >> n;
        ok = (n >= 1 && n <= PL);
        clear_stub();
        run_op(1'b0, c, a);
        chk(busy_seen, "R8 busy after start", busy_seen, 1);
        chk(!busy, "R8 busy low after done", busy, 0);
        chk_cmd_writes(0, c, a);
        chk(wn == 4, "R2 four writes", wn, 4);
        chk(bells == 1 && bell_wn[0] == 4, "R3 one doorbell after cmd write", bells, 1);
        chk(reads_per[0] == exp_reads(n), ok ? "R5 read count" : "R6 read count", reads_per[0], exp_reads(n));
        if (ok) begin
          chk(r_status == (16'h8000 >> n) && !r_tout && !r_fail, "R5 status result", r_status, 16'h8000 >> n);
        end else begin
          chk(r_status == 0 && r_tout && r_fail, "R6 timeout result", {r_tout, r_fail, r_status}, 32'h30000);
        end
      end
    end

    // Bus reset: first outcome x second outcome (0 ok, 1 error code, 2 timeout)
    ack_lat = 1;
    for (int f = 0; f < 3; f++) begin
      for (int s = 0; s < 3; s++) begin
        logic        exp_fail;
        logic [15:0] exp_stat;
        int          nb;
        cfg_after[0] = (f == 2) ? 0 : 2;
        cfg_val[0]   = (f == 1) ? 16'h0002 : OKC;
        cfg_after[1] = (s == 2) ? 0 : 3;
        cfg_val[1]   = (s == 1) ? 16'h0004 : OKC;
        clear_stub();
        run_op(1'b1, 16'h0000, 32'h0);
        nb = (f == 0) ? 2 : 1;
        exp_fail = !(f == 0 && s == 0);
        if (f != 0) exp_stat = (f == 1) ? 16'h0002 : 16'h0000;
        else exp_stat = (s == 0) ? OKC : ((s == 1) ? 16'h0004 : 16'h0000);
        chk(bells == nb && wn == 4 * nb, "R9 command count", bells, nb);
        chk_cmd_writes(0, RBEG, 32'h0);
        if (f == 0) begin
          chk_cmd_writes(4, RFIN, 32'h0);
          chk(hold_gap >= HOLD, "R9 hold gap", hold_gap, HOLD);
        end
        chk(r_fail == exp_fail, "R9 fail flag", r_fail, exp_fail);
        chk(r_status == exp_stat, "R9 last status", r_status, exp_stat);
      end
    end

    // R8: requests during busy are ignored
    ack_lat = 0;
    cfg_after[0] = 3; cfg_val[0] = 16'h0042;
    clear_stub();
    @(negedge clk);
    cmd_in = 16'h0BEE; arg_in = 32'h1234_5678; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    cmd_in = 16'h0DAD; arg_in = 32'hFFFF_0000; start = 1'b1; bus_reset_req = 1'b1;
    @(negedge clk);
    start = 1'b0; bus_reset_req = 1'b0;
    wait_done();
    repeat (40) @(negedge clk);
    chk(bells == 1 && wn == 4, "R8 extra requests ignored", wn, 4);
    chk(wlog_d[3] == 16'h0BEE, "R8 original command kept", wlog_d[3], 16'h0BEE);
    chk(r_status == 16'h0042 && !busy, "R8 result of first command", r_status, 16'h0042);

    // R10: start and bus reset together
    cfg_after[0] = 1; cfg_val[0] = 16'h0077;
    cfg_after[1] = 1; cfg_val[1] = OKC;
    clear_stub();
    @(negedge clk);
    cmd_in = 16'h0C0C; arg_in = 32'h0000_00FF; start = 1'b1; bus_reset_req = 1'b1;
    @(negedge clk);
    start = 1'b0; bus_reset_req = 1'b0;
    wait_done();
    repeat (40) @(negedge clk);
    chk(bells == 1 && wlog_d[3] == 16'h0C0C, "R10 single command wins", wlog_d[3], 16'h0C0C);
    chk(r_status == 16'h0077 && !r_fail, "R10 result", r_status, 16'h0077);

    // R4 poll spacing across the whole run
    chk(min_gap >= PI, "R4 min poll spacing", min_gap, PI);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule